// File: doc/BRIEF.md
# Single-Bit Object Stretcher

This block produces the serial pixel stream for a screen object whose graphics are a single bit, such as a projectile or a ball, on a scanline of 160 pixel clocks. The processor writes an enable bit. The object's horizontal position counter, which is outside this block, sends a one-cycle start pulse. After that pulse the block outputs the enable bit for 1, 2, 4 or 8 pixel clocks, as set by a two-bit size code.

An optional delay variant, selected by a parameter, adds a shadow copy of the enable bit. The shadow loads from the live bit on a separate copy strobe, which is normally the write strobe of a neighbouring object that is updated one line later. A delay-select bit chooses which of the two bits drives the output. This lets the object move vertically in single-line steps while its graphics are rewritten only every second line. Position counting, colour mapping and collision detection are left to other blocks.

Top module: `obj_stretch`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `obj_o` is 0. Reset clears the live enable bit, the shadow bit and the delay select, so a start pulse after reset with no write gives no output pixel.
- R2: A write (`en_we_i` = 1) loads `en_wdata_i` into the live enable bit at the next pixel-clock edge.
- R3: The size code sets the window width: code 0 gives 1 clock, 1 gives 2, 2 gives 4 and 3 gives 8. A start pulse sampled at a clock edge opens a window that covers exactly that many cycles, beginning with the cycle after that edge.
- R4: Whenever no window is open, `obj_o` is 0.
- R5: A start pulse during an open window restarts the count at the full width of the size code sampled with that pulse.
- R6: A copy strobe (`copy_i` = 1) loads the shadow bit with the value the live bit had before that edge, so a write in the same cycle does not reach the shadow.
- R7: When `dly_sel` is 0, the output uses the live bit. When it is 1, the output uses the shadow bit. The select is written with `dly_we_i`/`dly_wdata_i` and takes effect at the next edge.
- R8: During an open window, `obj_o` equals the selected enable bit, so a selected bit of 0 keeps the output low.
- R9: The size code is sampled only together with a start pulse; changing `size_i` inside a window leaves its width unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Write strobe for the live enable bit |
| en_wdata_i | input | 1 | Value for the live enable bit |
| copy_i | input | 1 | Copies the live bit into the shadow bit |
| dly_we_i | input | 1 | Write strobe for the delay select |
| dly_wdata_i | input | 1 | Delay select value (1 = shadow) |
| size_i | input | 2 | Width code: 2**size_i clocks |
| start_i | input | 1 | Start pulse from the position counter |
| obj_o | output | 1 | Serial object pixel |

## Verification
Every write, copy and start takes effect at the edge that samples it. The output is driven only from registered state, so the result of any stimulus is due in the cycle right after the edge that captured it. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It then compares `obj_o` at the next falling edge, one full edge after capture, with nothing left pending. Window widths are also counted directly by tallying the high cycles that follow one isolated start pulse.

// File: rtl/obj_stretch_pkg.sv
package obj_stretch_pkg;
  localparam int unsigned SIZE_W = 2;
  localparam int unsigned MAX_WIDTH = 1 << ((1 << SIZE_W) - 1);
  localparam int unsigned CNT_W = $clog2(MAX_WIDTH + 1);

  typedef logic [SIZE_W-1:0] size_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic cnt_t width_of(size_t code);
    return cnt_t'(1) << code;
  endfunction
endpackage

// File: rtl/obj_enable_regs.sv
module obj_enable_regs #(
  parameter bit HAS_DELAY = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_we_i,
  input  logic en_wdata_i,
  input  logic copy_i,
  input  logic dly_we_i,
  input  logic dly_wdata_i,
  output logic sel_bit_o
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      live_q <= 1'b0;
    else if (en_we_i) live_q <= en_wdata_i;
  end

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> live_q == $past(en_wdata_i));

  generate
    if (HAS_DELAY) begin : g_delay
      logic shadow_q, sel_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shadow_q <= 1'b0;
          sel_q    <= 1'b0;
        end else begin
          if (copy_i)   shadow_q <= live_q;
          if (dly_we_i) sel_q    <= dly_wdata_i;
        end
      end
      assign sel_bit_o = sel_q ? shadow_q : live_q;

      p_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        copy_i |=> shadow_q == $past(live_q));
      p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dly_we_i |=> $stable(sel_q));
    end else begin : g_plain
      logic unused_w;
      assign unused_w  = copy_i ^ dly_we_i ^ dly_wdata_i;
      assign sel_bit_o = live_q;
    end
  endgenerate
endmodule

// File: rtl/obj_width_ctr.sv
module obj_width_ctr
  import obj_stretch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  size_t size_i,
  output logic  active_o
);
  cnt_t remain_q, remain_d;

  always_comb begin
    remain_d = remain_q;
    if (start_i)              remain_d = width_of(size_i);
    else if (remain_q != '0)  remain_d = remain_q - cnt_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) remain_q <= '0;
    else         remain_q <= remain_d;
  end

  assign active_o = (remain_q != '0);

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> remain_q == width_of($past(size_i)));
  p_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && remain_q != '0) |=> remain_q == $past(remain_q) - cnt_t'(1));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_q <= cnt_t'(MAX_WIDTH));
endmodule

// File: rtl/obj_stretch.sv
module obj_stretch
  import obj_stretch_pkg::*;
#(
  parameter bit HAS_DELAY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              en_wdata_i,
  input  logic              copy_i,
  input  logic              dly_we_i,
  input  logic              dly_wdata_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              start_i,
  output logic              obj_o
);
  logic sel_bit_w, active_w;

  obj_enable_regs #(.HAS_DELAY(HAS_DELAY)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .copy_i      (copy_i),
    .dly_we_i    (dly_we_i),
    .dly_wdata_i (dly_wdata_i),
    .sel_bit_o   (sel_bit_w)
  );

  obj_width_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .size_i   (size_i),
    .active_o (active_w)
  );

  assign obj_o = active_w & sel_bit_w;

  p_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_w |-> !obj_o);
  p_start_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_w);
  p_reset_low_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !obj_o);
endmodule

// File: tb/obj_stretch_tb.sv
module obj_stretch_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_we = 0, en_wd = 0, copy = 0, dly_we = 0, dly_wd = 0, start = 0;
  logic [1:0] size = 0;
  logic obj;

  int vectors = 0, errors = 0;
  bit m_live = 0, m_shadow = 0, m_sel = 0;
  int m_rem = 0;

  always #10 clk = ~clk;

  obj_stretch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_we_i(en_we), .en_wdata_i(en_wd),
    .copy_i(copy), .dly_we_i(dly_we), .dly_wdata_i(dly_wd),
    .size_i(size), .start_i(start), .obj_o(obj)
  );

  function automatic int width_for(logic [1:0] c);
    return 1 << c;
  endfunction

  function automatic bit exp_out();
    return (m_rem != 0) && (m_sel ? m_shadow : m_live);
  endfunction

  task automatic check(bit exp, string req);
    vectors++;
    if (obj !== exp) begin
      errors++;
      $display("FAIL %s: obj_o=%b expected %b at %0t", req, obj, exp, $time);
    end
  endtask

  // inputs already driven; advance one cycle, update model, check at negedge
  task automatic cyc(string req);
    @(posedge clk);
    if (start) m_rem = width_for(size);
    else if (m_rem != 0) m_rem--;
    if (copy) m_shadow = m_live;
    if (en_we) m_live = en_wd;
    if (dly_we) m_sel = dly_wd;
    @(negedge clk);
    en_we = 0; copy = 0; dly_we = 0; start = 0;
    check(exp_out(), req);
  endtask

  task automatic width_count(logic [1:0] c, string req);
    int n = 0;
    size = c; start = 1;
    cyc(req);
    for (int i = 0; i < 12; i++) begin
      if (obj) n++;
      size = ~c;  // R9: size change inside window must not matter
      cyc(req);
    end
    vectors++;
    if (n != width_for(c)) begin
      errors++;
      $display("FAIL %s: width=%0d expected %0d (code %0d)", req, n, width_for(c), c);
    end
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog: timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1;
    check(1'b0, "R1");
    // R1: start after reset with cleared bits gives nothing
    start = 1; size = 3;
    cyc("R1");
    for (int i = 0; i < 8; i++) cyc("R1");
    // R2: write then start
    en_we = 1; en_wd = 1;
    cyc("R2");
    // R3 / R9 widths for every code
    for (int c = 0; c < 4; c++) width_count(2'(c), c == 3 ? "R9" : "R3");
    // R4: idle stretch
    for (int i = 0; i < 5; i++) cyc("R4");
    // R5: restart mid-window
    size = 2; start = 1; cyc("R5");
    cyc("R5"); cyc("R5");
    size = 3; start = 1; cyc("R5");
    for (int i = 0; i < 9; i++) cyc("R5");
    // R6 / R7: copy with simultaneous write, then select shadow
    copy = 1; en_we = 1; en_wd = 0; cyc("R6");
    dly_we = 1; dly_wd = 1; cyc("R7");
    size = 1; start = 1; cyc("R6");
    cyc("R7"); cyc("R7");
    dly_we = 1; dly_wd = 0; cyc("R7");
    // R8: selected bit zero keeps output low in window
    size = 3; start = 1; cyc("R8");
    for (int i = 0; i < 8; i++) cyc("R8");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      en_we  = ($urandom_range(0, 9) == 0);
      en_wd  = 1'($urandom);
      copy   = ($urandom_range(0, 9) == 0);
      dly_we = ($urandom_range(0, 29) == 0);
      dly_wd = 1'($urandom);
      size   = 2'($urandom);
      start  = ($urandom_range(0, 11) == 0);
      cyc(m_rem > 1 || start ? "R3" : "R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule